// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer (device side)

This block models the read datapath of a four-bank SDRAM device. It watches the command pins every rising clock edge and recognises a READ command. From that command it takes the bank, the starting column and the auto-precharge flag. It then produces one column address per clock for the length of the burst. Each address passes through a delay line whose depth equals the CAS latency. At the far end, a behavioural array turns the bank and column into a data word and drives it onto the DQ bus.

Fixed bursts of 1, 2, 4 or 8 words wrap inside an aligned block of columns. A full-page burst runs over all 512 columns of the row and keeps going until another READ replaces it. A new READ cuts any burst in progress, and its data follows the old data with no idle cycle. When no word is due, the DQ bus is released to high impedance. A burst that asked for auto precharge and ran to its end raises a one-cycle completion strobe for its bank.

CAS latency and burst length are static inputs. Activation, writes, refresh and mode-register programming belong to other blocks.

Top module: `sdram_rd_seq`

## Requirements
- R1: A command is a READ only when cs_n=0, ras_n=1, cas_n=0 and we_n=1 at a rising edge. Any other pin combination, including a READ pattern with cs_n=1, a write pattern (we_n=0) or an activate pattern (ras_n=0), starts no burst and leaves an idle bus released.
- R2: Take a READ sampled at edge T. The word for its starting column is valid at edge T+cas_lat, where cas_lat is 1, 2 or 3. The word at bank b and column c equals {5'b0, b[1:0], c[8:0]} XOR 16'hA5C3. The bank comes from ba, the column from addr[8:0], and the other address bits are ignored.
- R3: burst_sel is latched at the READ. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words, codes 4 to 6 give one word, and code 7 gives a full page. A fixed burst of length L yields one word per clock at columns (start & ~(L-1)) | ((start+k) & (L-1)) for k = 0..L-1.
- R4: A full-page burst yields column (start+k) mod 512 on every clock without end. It passes from column 511 to column 0, and it stops only when a new READ replaces it.
- R5: A READ issued while a burst is running ends the old burst. The old burst's last word is the one whose address was generated in the clock before the new READ. The new burst's first word follows it on the very next edge.
- R6: dq_oe is 1 exactly in the cycles that carry a burst word, and dq is high impedance otherwise. Once the last word of a burst has been shown, the bus is released unless another burst's word follows.
- R7: The READ is sampled with addr[10]=1 (auto precharge). When such a burst's final word is on the bus, pchg_done has exactly the bit of its bank set, for that one cycle. pchg_done stays 0 for bursts read with addr[10]=0, for truncated bursts and for full-page bursts.
- R8: While rst_n is low, dq_oe is 0, pchg_done is 0 and no burst is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus: column in [8:0], auto-precharge flag in [10] |
| cas_lat | input | 2 | CAS latency in clocks (1, 2 or 3) |
| burst_sel | input | 3 | Burst length code, latched at each READ |
| dq | output | 16 | Read data, high impedance when idle |
| dq_oe | output | 1 | High while dq carries a burst word |
| pchg_done | output | 4 | One-hot per-bank auto-precharge completion strobe |

## Verification
Single READs of every fixed length, each run until the bus goes idle, separate the wrap-within-block ordering and the end-of-burst release from a burst that overruns or stops early. Back-to-back bursts and a READ that cuts an auto-precharge burst in mid-flight tell gapless handover apart from a dropped or repeated word, and show that the cut burst never raises a precharge strobe. A full-page burst held for more than 512 clocks shows the 511-to-0 wrap and the absence of a natural end. Random READ traffic with random lengths, banks, columns and non-READ pin patterns is then run at all three CAS latencies. It shows whether the latency delay, the latching of burst_sel at each READ and the command decode hold together under overlap.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    parameter int ADDR_W = 13;
    parameter int COL_W  = 9;
    parameter int BA_W   = 2;
    parameter int BANKS  = 1 << BA_W;
    parameter int DQ_W   = 16;
    parameter int MAX_CL = 3;
    parameter int AP_BIT = 10;
    parameter int SEL_W  = 3;
    parameter logic [DQ_W-1:0] DATA_SALT = 16'hA5C3;

    localparam int CL_W  = $clog2(MAX_CL + 1);
    localparam int IDX_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;
    localparam logic [SEL_W-1:0] SEL_FULL = '1;

    typedef struct packed {
        logic            vld;
        logic [BA_W-1:0] bank;
        logic [COL_W-1:0] col;
        logic            ap;
        logic            last;
    } beat_t;

    // Mask of the column bits that move inside one burst.
    function automatic logic [COL_W-1:0] len_mask(input logic [SEL_W-1:0] sel);
        if (sel == SEL_FULL) begin
            return '1;
        end else if (sel[SEL_W-1]) begin
            return '0;
        end else begin
            return (COL_W'(1) << sel[1:0]) - COL_W'(1);
        end
    endfunction

    // Behavioural array contents, computed from the location.
    function automatic logic [DQ_W-1:0] cell_word(input logic [BA_W-1:0] bank,
                                                  input logic [COL_W-1:0] col);
        return DQ_W'({bank, col}) ^ DATA_SALT;
    endfunction

endpackage

// File: rtl/sdram_rd_decode.sv
module sdram_rd_decode
    import sdram_rd_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [COL_W-1:0]  col_o,
    output logic              ap_o
);

    logic unused_addr_bits;

    always_comb begin
        rd_o   = !cs_n && ras_n && !cas_n && we_n;
        bank_o = ba;
        col_o  = addr[COL_W-1:0];
        ap_o   = addr[AP_BIT];
    end

    assign unused_addr_bits = ^addr;

endmodule

// File: rtl/sdram_rd_colgen.sv
module sdram_rd_colgen
    import sdram_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic [BA_W-1:0]  bank_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             ap_i,
    input  logic [SEL_W-1:0] bl_sel_i,
    output beat_t            beat_o
);

    typedef struct packed {
        logic             act;
        logic [BA_W-1:0]  bank;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
        logic             ap;
    } gen_t;

    gen_t             s_d, s_q;
    logic [COL_W-1:0] new_mask;

    always_comb begin
        s_d      = s_q;
        beat_o   = '0;
        new_mask = len_mask(bl_sel_i);
        if (rd_i) begin
            // A READ always wins, cutting any running burst.
            beat_o.vld  = 1'b1;
            beat_o.bank = bank_i;
            beat_o.col  = col_i;
            beat_o.ap   = ap_i;
            beat_o.last = (new_mask == '0);
            s_d.act     = (new_mask != '0);
            s_d.bank    = bank_i;
            s_d.start   = col_i;
            s_d.cnt     = COL_W'(1);
            s_d.mask    = new_mask;
            s_d.ap      = ap_i;
        end else if (s_q.act) begin
            beat_o.vld  = 1'b1;
            beat_o.bank = s_q.bank;
            beat_o.col  = (s_q.start & ~s_q.mask) | ((s_q.start + s_q.cnt) & s_q.mask);
            beat_o.ap   = s_q.ap;
            beat_o.last = !(&s_q.mask) && (s_q.cnt == s_q.mask);
            s_d.cnt     = s_q.cnt + COL_W'(1);
            if (beat_o.last) begin
                s_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: a word that is not the last is always followed by another word.
    p_burst_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o.vld && !beat_o.last) |=> beat_o.vld);

    // R3: a fixed burst never counts past its length.
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && !(&s_q.mask)) |-> (s_q.cnt <= s_q.mask));

    // R4: a full-page burst stays alive unless a READ arrives.
    p_full_page_endless_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && (&s_q.mask) && !rd_i) |=> s_q.act);

    // R5: a READ over a running burst restarts the count.
    p_trunc_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && s_q.act) |=> (!s_q.act || s_q.cnt == COL_W'(1)));

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
    import sdram_rd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  beat_t           beat_i,
    input  logic [CL_W-1:0] cl_i,
    output beat_t           beat_o
);

    beat_t [MAX_CL-1:0] st_d, st_q;
    logic  [IDX_W-1:0]  tap;

    always_comb begin
        st_d[0] = beat_i;
        for (int i = 1; i < MAX_CL; i++) begin
            st_d[i] = st_q[i-1];
        end
        if (cl_i == '0) begin
            tap = '0;
        end else if (int'(cl_i) > MAX_CL) begin
            tap = IDX_W'(MAX_CL - 1);
        end else begin
            tap = IDX_W'(int'(cl_i) - 1);
        end
        beat_o = st_q[tap];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdram_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [SEL_W-1:0]  burst_sel,
    output wire  [DQ_W-1:0]   dq,
    output logic              dq_oe,
    output logic [BANKS-1:0]  pchg_done
);

    logic             rd_hit;
    logic [BA_W-1:0]  rd_bank;
    logic [COL_W-1:0] rd_col;
    logic             rd_ap;
    beat_t            gen_beat;
    beat_t            out_beat;

    sdram_rd_decode u_decode (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ba     (ba),
        .addr   (addr),
        .rd_o   (rd_hit),
        .bank_o (rd_bank),
        .col_o  (rd_col),
        .ap_o   (rd_ap)
    );

    sdram_rd_colgen u_colgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_hit),
        .bank_i   (rd_bank),
        .col_i    (rd_col),
        .ap_i     (rd_ap),
        .bl_sel_i (burst_sel),
        .beat_o   (gen_beat)
    );

    sdram_rd_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (gen_beat),
        .cl_i   (cas_lat),
        .beat_o (out_beat)
    );

    always_comb begin
        dq_oe     = out_beat.vld;
        pchg_done = '0;
        if (out_beat.vld && out_beat.last && out_beat.ap) begin
            pchg_done[out_beat.bank] = 1'b1;
        end
    end

    assign dq = dq_oe ? cell_word(out_beat.bank, out_beat.col) : {DQ_W{1'bz}};

    // R7: a completion strobe only accompanies a word on the bus.
    p_pchg_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pchg_done) |-> dq_oe);

    // R7: at most one bank completes at a time.
    p_pchg_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pchg_done));

endmodule

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;

    localparam int CLK_P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [1:0]  cas_lat = 2'd1;
    logic [2:0]  burst_sel = '0;
    wire  [15:0] dq;
    logic        dq_oe;
    logic [3:0]  pchg_done;

    int n_chk = 0;
    int n_fail = 0;

    // History of generated words: index j holds the word for j+1 clocks ago.
    logic       h_v[4];
    logic [1:0] h_b[4];
    logic [8:0] h_c[4];
    logic       h_ap[4];
    logic       h_last[4];
    int         h_tag[4];

    // Reference burst state.
    logic       m_act = 1'b0;
    logic [1:0] m_bank;
    logic [8:0] m_start;
    int         m_cnt, m_len;
    logic       m_full, m_ap;

    sdram_rd_seq u_sdram_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .cas_lat   (cas_lat),
        .burst_sel (burst_sel),
        .dq        (dq),
        .dq_oe     (dq_oe),
        .pchg_done (pchg_done)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            7: return "R7";
            8: return "R8";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [15:0] exp_word(input logic [1:0] b, input logic [8:0] c);
        return {5'b0, b, c} ^ 16'hA5C3;
    endfunction

    task automatic chk(input bit ok, input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag_name(tag), what, act, exp);
        end
    endtask

    // One clock: check the bus, drive the pins, advance the reference model.
    // kind: 0 nop, 1 READ pattern with cs_n high, 2 write pattern, 3 activate pattern.
    task automatic cycle(input bit rd, input logic [1:0] b, input logic [8:0] c,
                         input bit ap, input logic [2:0] sel, input int kind);
        int         idx;
        logic [15:0] w;
        logic [3:0] ep;
        logic       e_v, e_ap, e_last;
        logic [1:0] e_b;
        logic [8:0] e_c;
        int         e_tag;
        @(negedge clk);
        idx = int'(cas_lat) - 1;
        if (h_v[idx]) begin
            w  = exp_word(h_b[idx], h_c[idx]);
            chk(dq_oe === 1'b1 && dq === w, h_tag[idx], "data word",
                {15'b0, dq_oe, dq}, {15'b0, 1'b1, w});
            ep = (h_last[idx] && h_ap[idx]) ? (4'b0001 << h_b[idx]) : 4'b0;
            chk(pchg_done === ep, 7, "precharge strobe", {28'b0, pchg_done}, {28'b0, ep});
        end else begin
            chk(dq_oe === 1'b0, h_tag[idx], "bus released", {31'b0, dq_oe}, 32'b0);
            chk(pchg_done === 4'b0, 7, "precharge idle", {28'b0, pchg_done}, 32'b0);
        end

        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        addr = 13'($urandom);
        ba   = 2'($urandom);
        if (rd) begin
            cas_n = 1'b0;
            ba = b;
            addr[8:0] = c;
            addr[10] = ap;
            burst_sel = sel;
        end else begin
            burst_sel = 3'($urandom);
            case (kind)
                1: begin cs_n = 1'b1; cas_n = 1'b0; end
                2: begin cas_n = 1'b0; we_n = 1'b0; end
                3: ras_n = 1'b0;
                default: ;
            endcase
        end

        e_v = 1'b0; e_b = '0; e_c = '0; e_ap = 1'b0; e_last = 1'b0;
        e_tag = (kind != 0) ? 1 : 6;
        if (rd) begin
            e_tag   = m_act ? 5 : 2;
            m_full  = (sel == 3'd7);
            m_len   = m_full ? 512 : (sel >= 3'd4 ? 1 : (1 << sel));
            e_v = 1'b1; e_b = b; e_c = c; e_ap = ap;
            e_last  = !m_full && (m_len == 1);
            m_act   = !e_last;
            m_bank  = b; m_start = c; m_ap = ap; m_cnt = 1;
        end else if (m_act) begin
            e_v = 1'b1; e_b = m_bank; e_ap = m_ap;
            if (m_full) begin
                e_tag = 4;
                e_c   = 9'((int'(m_start) + m_cnt) % 512);
            end else begin
                e_tag = 3;
                e_c   = 9'(int'(m_start) - int'(m_start) % m_len
                           + (int'(m_start) % m_len + m_cnt) % m_len);
            end
            e_last = !m_full && (m_cnt == m_len - 1);
            m_cnt++;
            if (e_last) m_act = 1'b0;
        end

        for (int i = 3; i > 0; i--) begin
            h_v[i] = h_v[i-1]; h_b[i] = h_b[i-1]; h_c[i] = h_c[i-1];
            h_ap[i] = h_ap[i-1]; h_last[i] = h_last[i-1]; h_tag[i] = h_tag[i-1];
        end
        h_v[0] = e_v; h_b[0] = e_b; h_c[0] = e_c;
        h_ap[0] = e_ap; h_last[0] = e_last; h_tag[0] = e_tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 9'd0, 1'b0, 3'd0, 0);
    endtask

    task automatic rd(input logic [1:0] b, input logic [8:0] c, input bit ap,
                      input logic [2:0] sel);
        cycle(1'b1, b, c, ap, sel, 0);
    endtask

    task automatic run_phase();
        // R3: every fixed length, odd start columns to exercise the wrap.
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), 9'(8*s + 5), 1'b1, 3'(s));
            idle(12);
        end
        rd(2'd1, 9'd77, 1'b1, 3'd5);   // reserved code gives a single word
        idle(6);
        // R1: non-READ pin patterns while idle.
        for (int k = 1; k <= 3; k++) cycle(1'b0, 2'd0, 9'd0, 1'b0, 3'd0, k);
        idle(4);
        // R2: back-to-back fixed bursts of four.
        rd(2'd2, 9'd14, 1'b0, 3'd2);
        idle(3);
        rd(2'd3, 9'd300, 1'b1, 3'd2);
        idle(10);
        // R5: cut an auto-precharge burst of eight after three words.
        rd(2'd0, 9'd41, 1'b1, 3'd3);
        idle(2);
        rd(2'd1, 9'd510, 1'b1, 3'd1);
        idle(10);
        // R4: full page held past one complete lap, then cut.
        rd(2'd3, 9'd505, 1'b1, 3'd7);
        idle(520);
        rd(2'd2, 9'd3, 1'b1, 3'd0);
        idle(10);
        // Random traffic.
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 20) begin
                logic [2:0] sel;
                sel = ($urandom % 10 == 0) ? 3'd7 : 3'($urandom % 4);
                rd(2'($urandom), 9'($urandom), 1'($urandom), sel);
            end else if (r < 30) begin
                cycle(1'b0, 2'd0, 9'd0, 1'b0, 3'd0, 1 + int'($urandom % 3));
            end else begin
                idle(1);
            end
        end
        rd(2'd0, 9'd0, 1'b0, 3'd0);
        idle(10);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            h_v[i] = 1'b0; h_b[i] = '0; h_c[i] = '0;
            h_ap[i] = 1'b0; h_last[i] = 1'b0; h_tag[i] = 6;
        end
        // R8: a READ on the pins during reset must not show up.
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(dq_oe === 1'b0, 8, "reset bus", {31'b0, dq_oe}, 32'b0);
            chk(pchg_done === 4'b0, 8, "reset strobe", {28'b0, pchg_done}, 32'b0);
        end
        cas_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 1; p <= 3; p++) begin
            cas_lat = 2'(p);
            run_phase();
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog expired: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule